// File: doc/BRIEF.md
# Signature Reuse Insertion Predictor

This block learns, per access signature, whether cache lines brought in under that signature tend to be used again. It uses that knowledge to pick the re-reference value a new line receives when it is filled. Each table entry is a small saturating counter. A line's first hit raises the counter of the signature that inserted it. An eviction of a line that was never reused lowers that counter.

Demand and prefetch traffic learn apart from each other. The prefetch flag is placed below the signature to form the table index, so the two kinds of traffic use disjoint halves of the table. On the prediction side, each fill request returns a 2-bit insertion value one clock later:
- 3 (distant) for an unproven signature or a writeback.
- 0 (immediate) for a signature whose counter is at its ceiling.
- 2 (far) otherwise.

The signature width is a parameter. A width of 13 gives a table of 16K three-bit counters. The default width is kept smaller.

Top module: `sig_insert_predictor`

## Requirements
- R1: Reset clears every counter to 0 and drives `ins_vld_o` low.
- R2: The table index is `{signature, prefetch_flag}`, with the flag in the least significant bit. Training one half therefore never changes predictions made for the other half.
- R3: A training event with `trn_hit_i`=1 (first hit of a line) raises the addressed counter by one.
- R4: A training event with `trn_hit_i`=0 (eviction without reuse) lowers the addressed counter by one.
- R5: A raise applied to a counter already at its maximum (7 for 3-bit counters) leaves it at the maximum.
- R6: A lowering applied to a counter already at 0 leaves it at 0.
- R7: A prediction for a counter equal to 0 yields insertion value 3.
- R8: A prediction with `prd_wb_i`=1 yields 3, whatever the counter holds.
- R9: A non-writeback prediction for a counter at its maximum yields 0.
- R10: Every other non-writeback prediction yields 2. The value 1 is never produced.
- R11: When a training event and a prediction address the same entry in one cycle, the prediction uses the counter value from before that cycle's update.
- R12: Training events on consecutive cycles to one entry each take effect, with no update lost.
- R13: `ins_o` and `ins_vld_o` are registered. A prediction requested in cycle N is presented in cycle N+1, and `ins_vld_o` is high in N+1 exactly when `prd_vld_i` was high in N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trn_vld_i | input | 1 | Training event strobe |
| trn_hit_i | input | 1 | 1 = first hit (raise), 0 = unused eviction (lower) |
| trn_sig_i | input | SIG_W | Stored insertion signature of the trained line |
| trn_pf_i | input | 1 | Stored prefetch flag of the trained line |
| prd_vld_i | input | 1 | Prediction request strobe |
| prd_sig_i | input | SIG_W | Signature of the fill |
| prd_pf_i | input | 1 | Fill is a prefetch |
| prd_wb_i | input | 1 | Fill is a writeback |
| ins_vld_o | output | 1 | Insertion value valid |
| ins_o | output | 2 | Insertion re-reference value (0, 2 or 3) |

## Verification
Training and prediction can land on the same counter in one cycle. This case is provoked by raising one demand entry to 6 and then issuing a first-hit raise and a prediction for that entry together. The returned value must be 2, the reading before the update, and not the 0 that the updated value 7 would give. A prediction in the next cycle must then return 0, which shows the update was not lost. Back-to-back raises and lowers walk counters through both saturation limits. After each walk a prediction checks the result, so that a wrap-around or a dropped update shows up as a wrong insertion value.

// File: rtl/sig_insert_predictor.sv
module sig_insert_predictor #(
  parameter int SIG_W = 10,
  parameter int CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trn_vld_i,
  input  logic             trn_hit_i,
  input  logic [SIG_W-1:0] trn_sig_i,
  input  logic             trn_pf_i,
  input  logic             prd_vld_i,
  input  logic [SIG_W-1:0] prd_sig_i,
  input  logic             prd_pf_i,
  input  logic             prd_wb_i,
  output logic             ins_vld_o,
  output logic [1:0]       ins_o
);
  localparam int IDX_W = SIG_W + 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CONE = {{(CTR_W-1){1'b0}}, 1'b1};

  logic [CTR_W-1:0] tbl [DEPTH];

  logic [IDX_W-1:0] trn_idx, prd_idx;
  logic [CTR_W-1:0] trn_cnt, trn_nxt, prd_cnt;
  logic [1:0]       ins_nxt;

  assign trn_idx = {trn_sig_i, trn_pf_i};
  assign prd_idx = {prd_sig_i, prd_pf_i};
  assign trn_cnt = tbl[trn_idx];
  assign prd_cnt = tbl[prd_idx];

  assign trn_nxt = trn_hit_i ? ((trn_cnt == CMAX) ? trn_cnt : trn_cnt + CONE)
                             : ((trn_cnt == '0)   ? trn_cnt : trn_cnt - CONE);

  assign ins_nxt = (prd_wb_i || prd_cnt == '0) ? 2'd3 :
                   (prd_cnt == CMAX)            ? 2'd0 : 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (trn_vld_i) begin
      tbl[trn_idx] <= trn_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_vld_o <= 1'b0;
      ins_o     <= 2'd0;
    end else begin
      ins_vld_o <= prd_vld_i;
      if (prd_vld_i) ins_o <= ins_nxt;
    end
  end
endmodule

module sig_insert_predictor_chk #(
  parameter int CTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prd_vld_i,
  input logic             prd_wb_i,
  input logic [CTR_W-1:0] prd_cnt,
  input logic             ins_vld_o,
  input logic [1:0]       ins_o
);
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  // R13
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ins_vld_o == $past(prd_vld_i));

  // R8
  wb_distant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_vld_i && prd_wb_i) |=> (ins_vld_o && ins_o == 2'd3));

  // R7
  zero_distant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_vld_i && !prd_wb_i && prd_cnt == '0) |=> ins_o == 2'd3);

  // R9
  sat_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_vld_i && !prd_wb_i && prd_cnt == CMAX) |=> ins_o == 2'd0);

  // R10
  no_code_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld_o |-> ins_o != 2'd1);
endmodule

bind sig_insert_predictor sig_insert_predictor_chk #(.CTR_W(CTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .prd_vld_i(prd_vld_i), .prd_wb_i(prd_wb_i),
  .prd_cnt(prd_cnt), .ins_vld_o(ins_vld_o), .ins_o(ins_o)
);

// File: tb/sig_insert_predictor_tb.sv
`timescale 1ns/1ps
module sig_insert_predictor_tb_top;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trn_vld_i = 0, trn_hit_i = 0, trn_pf_i = 0;
  logic [SW-1:0] trn_sig_i = '0, prd_sig_i = '0;
  logic prd_vld_i = 0, prd_pf_i = 0, prd_wb_i = 0;
  logic ins_vld_o;
  logic [1:0] ins_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sig_insert_predictor #(.SIG_W(SW), .CTR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .trn_vld_i(trn_vld_i), .trn_hit_i(trn_hit_i), .trn_sig_i(trn_sig_i), .trn_pf_i(trn_pf_i),
    .prd_vld_i(prd_vld_i), .prd_sig_i(prd_sig_i), .prd_pf_i(prd_pf_i), .prd_wb_i(prd_wb_i),
    .ins_vld_o(ins_vld_o), .ins_o(ins_o)
  );

  // op: 0 = first-hit train, 1 = unused-evict train, 2 = predict and compare
  typedef struct packed {
    logic [1:0] op;
    logic [3:0] sig;
    logic       pf;
    logic       wb;
    logic [1:0] exp;
    logic [7:0] req;
  } vec_t;

  function automatic vec_t v(int op, int sig, int pf, int wb, int exp, int req);
    v = '{op: 2'(op), sig: 4'(sig), pf: 1'(pf), wb: 1'(wb), exp: 2'(exp), req: 8'(req)};
  endfunction

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    v(2,3,0,0,3,7),                                   // R7 fresh counter
    v(0,3,0,0,0,3),
    v(2,3,0,0,2,3),                                   // R3 one raise -> far
    v(2,3,1,0,3,2),                                   // R2 prefetch half untouched
    v(2,3,0,1,3,8),                                   // R8 writeback
    v(0,3,0,0,0,12), v(0,3,0,0,0,12), v(0,3,0,0,0,12),// R12 back-to-back raises
    v(0,3,0,0,0,12), v(0,3,0,0,0,12), v(0,3,0,0,0,12),
    v(2,3,0,0,0,9),                                   // R9 saturated -> immediate
    v(0,3,0,0,0,5),
    v(2,3,0,0,0,5),                                   // R5 no wrap past 7
    v(1,3,0,0,0,4), v(1,3,0,0,0,4), v(1,3,0,0,0,4),
    v(1,3,0,0,0,4), v(1,3,0,0,0,4), v(1,3,0,0,0,4),
    v(2,3,0,0,2,4),                                   // R4 lowered to 1
    v(1,3,0,0,0,4),
    v(2,3,0,0,3,4),                                   // R4 lowered to 0
    v(1,3,0,0,0,6),
    v(0,3,0,0,0,6),
    v(2,3,0,0,2,6),                                   // R6 held at 0 then 1
    v(2,3,0,1,3,8),                                   // R8 writeback over count 1
    v(0,5,1,0,0,2), v(0,5,1,0,0,2), v(0,5,1,0,0,2), v(0,5,1,0,0,2),
    v(0,5,1,0,0,2), v(0,5,1,0,0,2), v(0,5,1,0,0,2),
    v(2,5,1,0,0,2),                                   // R2 prefetch half saturated
    v(2,5,0,0,3,2),                                   // R2 demand half still 0
    v(2,5,1,1,3,8)                                    // R8 writeback over saturated
  };

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    trn_vld_i = 0; prd_vld_i = 0; prd_wb_i = 0;
  endtask

  task automatic hit(int sig, int pf);
    trn_vld_i = 1; trn_hit_i = 1; trn_sig_i = SW'(sig); trn_pf_i = pf[0];
  endtask

  task automatic pred(int sig, int pf, int wb);
    prd_vld_i = 1; prd_sig_i = SW'(sig); prd_pf_i = pf[0]; prd_wb_i = wb[0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vld low in reset", {1'b0, ins_vld_o}, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld low after reset", {1'b0, ins_vld_o}, 2'd0);

    for (int k = 0; k < NV; k++) begin
      idle();
      if (VEC[k].op == 2'd2) pred(VEC[k].sig, VEC[k].pf, VEC[k].wb);
      else begin
        trn_vld_i = 1; trn_hit_i = (VEC[k].op == 2'd0);
        trn_sig_i = SW'(VEC[k].sig); trn_pf_i = VEC[k].pf;
      end
      @(negedge clk);
      if (VEC[k].op == 2'd2)
        check($sformatf("R%0d vector %0d", VEC[k].req, k), ins_o, VEC[k].exp);
    end

    // R11: same-cycle train and predict on one entry
    idle();
    for (int k = 0; k < 6; k++) begin hit(7, 0); @(negedge clk); end
    hit(7, 0); pred(7, 0, 0);
    @(negedge clk);
    check("R11 pre-update value", ins_o, 2'd2);
    idle(); pred(7, 0, 0);
    @(negedge clk);
    check("R11 update kept", ins_o, 2'd0);

    // R13: valid follows request by one cycle
    idle();
    check("R13 vld with request", {1'b0, ins_vld_o}, 2'd1);
    @(negedge clk);
    check("R13 vld drops", {1'b0, ins_vld_o}, 2'd0);

    // R1: reset clears trained counters
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pred(5, 1, 0);
    @(negedge clk);
    check("R1 counter cleared", ins_o, 2'd3);
    idle();
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule